// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This block holds the event status word of a network controller and turns it into one level interrupt line. The transmit and receive engines report events through one-cycle set pulses. Each pulse sets a sticky bit in the status word, and software clears bits by writing ones to them. Every event belongs to one of two classes, normal completions or abnormal conditions. Each class has a summary bit inside the status word, and the interrupt line is raised whenever either summary is set.

The unit also decodes a small bank of sixteen 32-bit control registers, placed at an 8-byte pitch. A read of the status word also reports the receive and transmit process-state fields. These fields are not stored; they are built at read time from the start bits of the operating-mode register. The missed-frame counter register always reads as zero and is cleared by the read. Accesses at misaligned offsets or past the last register are dropped.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, the status register (index 5, offset 0x28) reads 0xFC000000, the bus-mode register (index 0, offset 0x00) reads 0xFFF80000, and `irq` is low.
- R2: A pulse on `evt_pulse[k]` for k = 0..10 sets status bit 0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13 respectively. These are transmit done, transmit stopped, transmit buffer unavailable, jabber, underflow, receive done, receive buffer unavailable, receive stopped, receive watchdog, timer expired and fatal bus error.
- R3: Status bit 16 (normal summary) is set exactly when any of bits 0, 2 or 6 is set.
- R4: Status bit 15 (abnormal summary) is set exactly when any of bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R5: `irq` equals (bit 15 OR bit 16) of the status word as it stood one clock earlier. It therefore changes one cycle after the status bits change.
- R6: A write to offset 0x28 clears every status bit whose written value is one and leaves the other bits unchanged. The summary bits are then recomputed.
- R7: When a set pulse and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R8: A status read ORs 3 into bits 19:17 when operating-mode (index 6, offset 0x30) bit 1 is set. It ORs 3 into bits 22:20 when operating-mode bit 13 is set.
- R9: A read of the missed-frame register (index 8, offset 0x40) returns zero and clears the register, even after that register has been written.
- R10: An access whose offset is not a multiple of 8, or whose register index is above 15, changes no register and produces no read response.
- R11: Every register other than status and missed-frame stores the written 32-bit value and returns it on read.
- R12: A valid read request gives `bus_rvalid` high with the data one clock later, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| evt_pulse | input | 11 | One-cycle event set pulses from the engines |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit offset and an 8-byte stride. This leaves the register-index field one bit wider than needed, so offsets from 0x80 upward reach past register 15. The stride also leaves offsets 1..7 inside each slot, so misaligned accesses can occur. Both kinds of dropped access can therefore be driven at the ports. Random event pulses, mixed with random write-one masks and operating-mode changes, cover the summary classes, the same-cycle set-and-clear case and the one-cycle interrupt lag.

// File: rtl/nicsts_pkg.sv
package nicsts_pkg;

    localparam int CSR_W     = 32;
    localparam int NUM_EVT   = 11;
    localparam int NUM_CSR   = 16;
    localparam int CSR_IDX_W = $clog2(NUM_CSR);

    // register indices that carry special behaviour
    localparam int IDX_BUSMODE = 0;
    localparam int IDX_STATUS  = 5;
    localparam int IDX_OPMODE  = 6;
    localparam int IDX_MISSED  = 8;

    // status word layout
    localparam int SUM_ABN_BIT = 15;
    localparam int SUM_NRM_BIT = 16;
    localparam int RXPS_LSB    = 17;
    localparam int TXPS_LSB    = 20;

    // operating-mode start bits
    localparam int OPM_RX_START = 1;
    localparam int OPM_TX_START = 13;

    typedef enum logic [3:0] {
        EV_TX_DONE, EV_TX_STOP, EV_TX_NOBUF, EV_JABBER, EV_UNDERFLOW,
        EV_RX_DONE, EV_RX_NOBUF, EV_RX_STOP, EV_RX_WDOG, EV_TIMER,
        EV_BUS_FAULT
    } evt_e;

    typedef struct packed {
        logic                 rd;
        logic                 wr;
        logic [CSR_IDX_W-1:0] idx;
        logic [CSR_W-1:0]     data;
    } csr_req_t;

    // status bit position of each event input
    function automatic int evt_bit(int k);
        case (k)
            int'(EV_TX_DONE):   return 0;
            int'(EV_TX_STOP):   return 1;
            int'(EV_TX_NOBUF):  return 2;
            int'(EV_JABBER):    return 3;
            int'(EV_UNDERFLOW): return 5;
            int'(EV_RX_DONE):   return 6;
            int'(EV_RX_NOBUF):  return 7;
            int'(EV_RX_STOP):   return 8;
            int'(EV_RX_WDOG):   return 9;
            int'(EV_TIMER):     return 11;
            default:            return 13;
        endcase
    endfunction

    // completions and missing transmit buffers are ordinary traffic
    function automatic logic evt_is_abnormal(int k);
        return !(k == int'(EV_TX_DONE) || k == int'(EV_TX_NOBUF) ||
                 k == int'(EV_RX_DONE));
    endfunction

    function automatic logic [CSR_W-1:0] class_mask(logic abnormal);
        logic [CSR_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_EVT; k++)
            if (evt_is_abnormal(k) == abnormal) m[evt_bit(k)] = 1'b1;
        return m;
    endfunction

    function automatic logic [CSR_W-1:0] csr_reset_val(int idx);
        case (idx)
            IDX_BUSMODE: return 32'hFFF8_0000;
            IDX_STATUS:  return 32'hFC00_0000;
            IDX_MISSED:  return 32'hFFFE_0000;
            default:     return '0;
        endcase
    endfunction

    // process-state fields reported alongside the status word
    function automatic logic [CSR_W-1:0] proc_state(logic [CSR_W-1:0] opm);
        logic [CSR_W-1:0] r;
        r = '0;
        if (opm[OPM_RX_START]) r[RXPS_LSB +: 3] = 3'd3;
        if (opm[OPM_TX_START]) r[TXPS_LSB +: 3] = 3'd3;
        return r;
    endfunction

endpackage

// File: rtl/nicsts_decode.sv
module nicsts_decode
    import nicsts_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STRIDE = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CSR_W-1:0]  wdata,
    output logic              hit,
    output csr_req_t          req
);
    localparam int SH     = $clog2(STRIDE);
    localparam int SLOT_W = ADDR_W - SH;

    logic [SLOT_W-1:0] slot;
    logic              aligned;
    logic              in_range;

    assign slot    = addr[ADDR_W-1:SH];
    assign aligned = (addr[SH-1:0] == '0);

    generate
        if (SLOT_W > CSR_IDX_W) begin : g_range
            assign in_range = (slot[SLOT_W-1:CSR_IDX_W] == '0);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    assign hit      = aligned & in_range;
    assign req.rd   = sel & ~wr & hit;
    assign req.wr   = sel & wr & hit;
    assign req.idx  = slot[CSR_IDX_W-1:0];
    assign req.data = wdata;

endmodule

// File: rtl/nicsts_status.sv
module nicsts_status
    import nicsts_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_en,
    input  logic [CSR_W-1:0]   clr_mask,
    output logic [CSR_W-1:0]   sts_o,
    output logic               irq_o
);
    localparam logic [CSR_W-1:0] NRM_MASK = class_mask(1'b0);
    localparam logic [CSR_W-1:0] ABN_MASK = class_mask(1'b1);
    localparam logic [CSR_W-1:0] SUM_MASK =
        (CSR_W'(1) << SUM_ABN_BIT) | (CSR_W'(1) << SUM_NRM_BIT);

    logic [CSR_W-1:0] sts_q, sts_d, set_vec, kept;
    logic             irq_q;

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < NUM_EVT; k++)
            set_vec[evt_bit(k)] = set_vec[evt_bit(k)] | evt_i[k];
    end

    // clear first, then set: a simultaneous event survives
    always_comb begin
        kept  = clr_en ? (sts_q & ~clr_mask) : sts_q;
        sts_d = kept | set_vec;
        sts_d[SUM_ABN_BIT] = |(sts_d & ABN_MASK);
        sts_d[SUM_NRM_BIT] = |(sts_d & NRM_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= csr_reset_val(IDX_STATUS);
            irq_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
            irq_q <= sts_q[SUM_ABN_BIT] | sts_q[SUM_NRM_BIT];
        end
    end

    assign sts_o = sts_q;
    assign irq_o = irq_q;

    generate
        for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt_chk
            localparam int P = evt_bit(g);
            AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
                evt_i[g] |=> sts_q[P]); // R7
        end
    endgenerate

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((sts_q & $past(clr_mask) & ~$past(set_vec) & ~SUM_MASK) == '0)); // R6

    AST_NRM_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        sts_q[SUM_NRM_BIT] == |(sts_q & NRM_MASK)); // R3

    AST_ABN_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        sts_q[SUM_ABN_BIT] == |(sts_q & ABN_MASK)); // R4

endmodule

// File: rtl/nicsts_regfile.sv
module nicsts_regfile
    import nicsts_pkg::*;
#(
    parameter int NUM_REGS = NUM_CSR
) (
    input  logic             clk,
    input  logic             rst,
    input  csr_req_t         req,
    output logic [CSR_W-1:0] rd_word,
    output logic [CSR_W-1:0] opmode_o
);
    logic [NUM_REGS-1:0][CSR_W-1:0] bank;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            if (i == IDX_STATUS) begin : g_hole
                assign bank[i] = '0;
            end else begin : g_store
                logic [CSR_W-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst)
                        q <= csr_reset_val(i);
                    else if (req.wr && req.idx == CSR_IDX_W'(i))
                        q <= req.data;
                    else if (i == IDX_MISSED && req.rd && req.idx == CSR_IDX_W'(i))
                        q <= '0;
                end
                assign bank[i] = q;
            end
        end
    endgenerate

    assign rd_word  = (req.idx == CSR_IDX_W'(IDX_MISSED)) ? '0 : bank[req.idx];
    assign opmode_o = bank[IDX_OPMODE];

    AST_MISSED_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.idx == CSR_IDX_W'(IDX_MISSED)) |=> (bank[IDX_MISSED] == '0)); // R9

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nicsts_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STRIDE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CSR_W-1:0]   bus_wdata,
    output logic [CSR_W-1:0]   bus_rdata,
    output logic               bus_rvalid,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);
    csr_req_t         req;
    logic             hit;
    logic [CSR_W-1:0] sts, rf_word, opmode, rd_mux;
    logic             is_status;
    logic [CSR_W-1:0] rdata_q;
    logic             rvalid_q;

    nicsts_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_decode (
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .hit   (hit),
        .req   (req)
    );

    assign is_status = (req.idx == CSR_IDX_W'(IDX_STATUS));

    nicsts_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_pulse),
        .clr_en   (req.wr && is_status),
        .clr_mask (req.data),
        .sts_o    (sts),
        .irq_o    (irq)
    );

    nicsts_regfile #(.NUM_REGS(NUM_CSR)) u_regfile (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rd_word  (rf_word),
        .opmode_o (opmode)
    );

    assign rd_mux = is_status ? (sts | proc_state(opmode)) : rf_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= req.rd;
            if (req.rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    AST_IRQ_LAGS_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        irq == $past(sts[SUM_ABN_BIT] | sts[SUM_NRM_BIT])); // R5

    AST_BAD_ACCESS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !hit) |=> !bus_rvalid); // R10

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && hit) |=> bus_rvalid); // R12

    AST_RX_FIELD_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && hit && is_status && opmode[OPM_RX_START])
            |=> (bus_rdata[RXPS_LSB +: 3] == 3'd3)); // R8

endmodule

// File: tb/test_nic_irq_status.sv
module test_nic_irq_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [10:0] evt = '0;
    logic        irq;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    logic [31:0] m_sts;
    logic [31:0] m_mode;

    always #5 clk = ~clk;

    nic_irq_status i_nic_irq_status (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
        .evt_pulse(evt), .irq(irq)
    );

    function automatic int pos_of(int k);
        int t[11] = '{0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13};
        return t[k];
    endfunction

    function automatic logic [31:0] with_sums(logic [31:0] s);
        logic [31:0] r = s;
        r[16] = s[0] | s[2] | s[6];
        r[15] = s[1] | s[3] | s[5] | s[7] | s[8] | s[9] | s[11] | s[13];
        return r;
    endfunction

    function automatic logic [31:0] ps_of(logic [31:0] mode);
        logic [31:0] r = '0;
        if (mode[1])  r = r | (32'd3 << 17);
        if (mode[13]) r = r | (32'd3 << 20);
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        @(negedge clk); sel = 0; d = rdata; v = rvalid;
    endtask

    // one event/clear cycle, with the interrupt lag checked on both sides
    task automatic step(logic [10:0] e, bit clr, logic [31:0] mask, string tag);
        logic old_irq;
        logic [31:0] setv;
        old_irq = m_sts[15] | m_sts[16];
        setv = '0;
        for (int k = 0; k < 11; k++) if (e[k]) setv[pos_of(k)] = 1'b1;
        @(negedge clk);
        evt = e;
        if (clr) begin sel = 1; wr = 1; addr = 8'h28; wdata = mask; end
        @(negedge clk);
        evt = '0; sel = 0; wr = 0;
        m_sts = with_sums((clr ? (m_sts & ~mask) : m_sts) | setv);
        check({tag, " R5 irq before lag"}, 32'(irq), 32'(old_irq));
        @(negedge clk);
        check({tag, " R5 irq after lag"}, 32'(irq), 32'(m_sts[15] | m_sts[16]));
    endtask

    task automatic check_status(string tag);
        logic [31:0] d; logic v;
        bus_read(8'h28, d, v);
        check({tag, " valid"}, 32'(v), 32'd1);
        check(tag, d, m_sts | ps_of(m_mode));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic v;
        void'($urandom(32'd20240611));
        m_sts  = 32'hFC00_0000;
        m_mode = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 irq at reset", 32'(irq), 32'd0);
        check_status("R1 status reset");
        bus_read(8'h00, d, v);
        check("R1 bus-mode reset", d, 32'hFFF8_0000);
        // R12 response lasts one cycle
        @(negedge clk);
        check("R12 rvalid drops", 32'(rvalid), 32'd0);

        // R9 missed-frame reads zero, even after a write
        bus_read(8'h40, d, v);
        check("R9 missed read zero", d, 32'h0);
        check("R12 missed valid", 32'(v), 32'd1);
        bus_write(8'h40, 32'h1234_5678);
        bus_read(8'h40, d, v);
        check("R9 missed after write", d, 32'h0);

        // R11 plain storage
        bus_write(8'h10, 32'hA5A5_0F0F);
        bus_read(8'h10, d, v);
        check("R11 plain reg", d, 32'hA5A5_0F0F);
        bus_write(8'h78, 32'h0BAD_CAFE);
        bus_read(8'h78, d, v);
        check("R11 last reg", d, 32'h0BAD_CAFE);

        // wipe status, then R2 each event position alone
        step('0, 1, 32'hFFFF_FFFF, "R6 wipe");
        check_status("R6 wiped");
        for (int k = 0; k < 11; k++) begin
            step(11'(1) << k, 0, '0, "R2 single");
            check_status("R2 single event bit");
            step('0, 1, 32'hFFFF_FFFF, "R6 clear all");
        end

        // R3 transmit buffer unavailable is normal only
        step(11'(1) << 2, 0, '0, "R3 nobuf");
        check_status("R3 normal summary only");
        step('0, 1, 32'h0000_0004, "R6 clear nobuf");
        check_status("R6 cleared nobuf");
        // R4 fatal bus error is abnormal only
        step(11'(1) << 10, 0, '0, "R4 bus fault");
        check_status("R4 abnormal summary only");
        // R7 set and clear of bit 0 together
        step(11'(1), 1, 32'h0000_0001, "R7 collide");
        check_status("R7 set wins");
        step('0, 1, 32'hFFFF_FFFF, "R6 clear all");

        // R8 process-state fields
        m_mode = 32'h0000_2002;
        bus_write(8'h30, m_mode);
        check_status("R8 both starts");
        m_mode = 32'h0000_0002;
        bus_write(8'h30, m_mode);
        check_status("R8 rx start only");

        // R10 dropped accesses
        step(11'(1) << 5, 0, '0, "R10 setup");
        bus_write(8'h29, 32'hFFFF_FFFF);
        check_status("R10 misaligned write ignored");
        bus_read(8'h2C, d, v);
        check("R10 misaligned read silent", 32'(v), 32'd0);
        bus_write(8'h80, 32'h0);
        bus_read(8'h00, d, v);
        check("R10 out-of-range write ignored", d, 32'hFFF8_0000);
        bus_read(8'h80, d, v);
        check("R10 out-of-range read silent", 32'(v), 32'd0);

        // random mix: R2 R3 R4 R5 R6 R7 R8
        for (int it = 0; it < 400; it++) begin
            logic [10:0] e;
            e = '0;
            for (int k = 0; k < 11; k++) e[k] = ($urandom % 6) == 0;
            if (($urandom % 16) == 0) begin
                m_mode = $urandom;
                bus_write(8'h30, m_mode);
            end
            step(e, ($urandom % 2) == 1, $urandom, "R6 random");
            if ((it % 3) == 0) check_status("R3 R4 random status");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule